// File: doc/BRIEF.md
# SDRAM Command Protocol Checker

This block watches an SDRAM command bus without driving it. On every rising clock edge it samples the command strobes, the clock-enable level, the bank select, the auto-precharge/all-banks address bit and the three low address bits. It turns that sample into a command code and tracks whether each bank has a row open. Errors are recorded in a vector of sticky flags. The checker sits beside a memory controller in simulation or in silicon, and reports protocol violations that the controller should never produce.

Bank state follows the bus. An activate opens a bank. A precharge closes the addressed bank, or every bank when the address bit is high. A read or write with auto-precharge closes its bank when the burst ends. The burst length comes from the last mode load. A down-counter blocks commands for a parameterised number of cycles after each mode load. Stored data and analog timing are not modelled.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: `cmd_code` shows the command sampled at the previous edge. Select and strobes are read as {cs_n,ras_n,cas_n,we_n}: cs_n high or 0111 gives 0 (no-op), 0011 gives 1 (activate), 0101 gives 2 (read), 0100 gives 3 (write), 0110 gives 4 (burst stop), 0010 gives 5 (precharge), 0000 gives 8 (mode load).
- R2: An activate sets `bank_open[ba]`. An activate to a bank that is already open sets `err_vec[0]`.
- R3: A read or write to a bank that is not open sets `err_vec[1]` and leaves all bank state unchanged.
- R4: A precharge with `a10` low clears only `bank_open[ba]`. With `a10` high it clears every bank.
- R5: A read or write with `a10` high at edge k keeps its bank open through edge k+BL-1 and clears it at edge k+BL. BL is decoded from `a_bl` of the last mode load: 0→1, 1→2, 2→4, 3→8, 7→FULL_PAGE, any other value→1. After reset BL is 1.
- R6: A mode load while any bank is open sets `err_vec[2]`.
- R7: After a mode load at edge k, any command other than a no-op at edges k+1 to k+T_MRD-1 sets `err_vec[3]`. A command at edge k+T_MRD is legal.
- R8: Encoding 0001 decodes to 6 (auto refresh) when `cke` is high and to 7 (self refresh) when `cke` is low. An auto refresh while any bank is open sets `err_vec[4]`.
- R9: Synchronous reset sets `cmd_code` to 0, `bank_open` to 0 and `err_vec` to 0. Outside reset, an error bit, once set, stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable level |
| ba | input | $clog2(NBANK) | Bank select |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| a_bl | input | 3 | Address bits 2..0, the burst-length field on a mode load |
| cmd_code | output | 4 | Last decoded command |
| bank_open | output | NBANK | One bit per bank, set while a row is open |
| err_vec | output | 5 | Sticky protocol error flags |

## Verification
The bench builds the checker with four banks, a mode-load spacing of three cycles and a full page of sixteen beats. The spacing of three leaves two forbidden cycles after a mode load, so both the last illegal cycle and the first legal one can be exercised. The sixteen-beat full page lets the full-page auto-precharge close be observed cycle by cycle in a short run. A burst length of two, set by a mode load inside the vector table, checks the per-bank countdown at its smallest non-trivial length.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

   typedef enum logic [3:0] {
      CMD_NOP  = 4'd0,
      CMD_ACT  = 4'd1,
      CMD_RD   = 4'd2,
      CMD_WR   = 4'd3,
      CMD_BST  = 4'd4,
      CMD_PRE  = 4'd5,
      CMD_AREF = 4'd6,
      CMD_SREF = 4'd7,
      CMD_LMR  = 4'd8
   } sdcm_cmd_e;

   localparam int ERR_W      = 5;
   localparam int E_ACT_OPEN = 0;
   localparam int E_RW_IDLE  = 1;
   localparam int E_LMR_BUSY = 2;
   localparam int E_MRD      = 3;
   localparam int E_REF_BUSY = 4;

   function automatic int unsigned bl_beats(input logic [2:0] code, input int unsigned full);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 8;
         3'd7:    return full;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/sdcm_decode.sv
module sdcm_decode
   import sdcm_pkg::*;
(
   input  logic      cs_n,
   input  logic      ras_n,
   input  logic      cas_n,
   input  logic      we_n,
   input  logic      cke,
   output sdcm_cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_NOP;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b110:  cmd = CMD_BST;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
            3'b000:  cmd = CMD_LMR;
            default: cmd = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sdcm_bank.sv
module sdcm_bank
   import sdcm_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit,
   input  sdcm_cmd_e        cmd,
   input  logic             ap,
   input  logic [CNT_W-1:0] bl,
   output logic             open_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             is_open_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         is_open_q <= 1'b0;
         cnt_q     <= '0;
      end else if (cmd == CMD_PRE && (ap || hit)) begin
         is_open_q <= 1'b0;
         cnt_q     <= '0;
      end else if (hit && cmd == CMD_ACT && !is_open_q) begin
         is_open_q <= 1'b1;
         cnt_q     <= '0;
      end else if (hit && (cmd == CMD_RD || cmd == CMD_WR) && is_open_q && ap) begin
         cnt_q <= bl;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) is_open_q <= 1'b0;
      end
   end

   assign open_o = is_open_q;

   assert_apc_close_R5: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CNT_W'(1) && cmd == CMD_NOP) |=> !open_o);

   assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
      (hit && cmd == CMD_ACT && cnt_q == '0) |=> open_o);

endmodule

// File: rtl/sdcm_mrd.sv
module sdcm_mrd #(
   parameter int T_MRD = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   output logic busy
);

   generate
      if (T_MRD <= 1) begin : g_none
         assign busy = 1'b0;
      end else begin : g_cnt
         localparam int W = $clog2(T_MRD);
         logic [W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)                cnt_q <= '0;
            else if (load)          cnt_q <= W'(T_MRD - 1);
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end

         assign busy = (cnt_q != '0);

         assert_mrd_arm_R7: assert property (@(posedge clk) disable iff (rst)
            load |=> busy);
      end
   endgenerate

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdcm_pkg::*;
#(
   parameter int NBANK     = 4,
   parameter int T_MRD     = 2,
   parameter int FULL_PAGE = 512,
   localparam int BA_W     = $clog2(NBANK),
   localparam int CNT_W    = $clog2(FULL_PAGE + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             cke,
   input  logic [BA_W-1:0]  ba,
   input  logic             a10,
   input  logic [2:0]       a_bl,
   output logic [3:0]       cmd_code,
   output logic [NBANK-1:0] bank_open,
   output logic [ERR_W-1:0] err_vec
);

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("NBANK must be a power of two of at least 2");
   end
   if (T_MRD < 1) begin : g_bad_mrd
      $error("T_MRD must be at least 1");
   end
   if (FULL_PAGE < 8) begin : g_bad_page
      $error("FULL_PAGE must be at least 8");
   end

   sdcm_cmd_e        cmd_now;
   sdcm_cmd_e        cmd_q;
   logic [CNT_W-1:0] mode_bl_q;
   logic [ERR_W-1:0] err_q;
   logic [ERR_W-1:0] err_new;
   logic             mrd_busy;
   logic             any_open;

   sdcm_decode u_decode (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cke   (cke),
      .cmd   (cmd_now)
   );

   sdcm_mrd #(.T_MRD(T_MRD)) u_mrd (
      .clk  (clk),
      .rst  (rst),
      .load (cmd_now == CMD_LMR),
      .busy (mrd_busy)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      sdcm_bank #(.CNT_W(CNT_W)) u_bank (
         .clk    (clk),
         .rst    (rst),
         .hit    (ba == BA_W'(b)),
         .cmd    (cmd_now),
         .ap     (a10),
         .bl     (mode_bl_q),
         .open_o (bank_open[b])
      );
   end

   assign any_open = |bank_open;

   always_comb begin
      err_new             = '0;
      err_new[E_ACT_OPEN] = (cmd_now == CMD_ACT) && bank_open[ba];
      err_new[E_RW_IDLE]  = (cmd_now == CMD_RD || cmd_now == CMD_WR) && !bank_open[ba];
      err_new[E_LMR_BUSY] = (cmd_now == CMD_LMR) && any_open;
      err_new[E_MRD]      = mrd_busy && (cmd_now != CMD_NOP);
      err_new[E_REF_BUSY] = (cmd_now == CMD_AREF) && any_open;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q     <= CMD_NOP;
         err_q     <= '0;
         mode_bl_q <= CNT_W'(1);
      end else begin
         cmd_q <= cmd_now;
         err_q <= err_q | err_new;
         if (cmd_now == CMD_LMR) mode_bl_q <= CNT_W'(bl_beats(a_bl, FULL_PAGE));
      end
   end

   assign cmd_code = cmd_q;
   assign err_vec  = err_q;

   assert_nop_decode_R1: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> cmd_code == 4'd0);

   assert_act_err_R2: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !ras_n && cas_n && we_n && bank_open[ba]) |=> err_vec[E_ACT_OPEN]);

   assert_rw_err_R3: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && ras_n && !cas_n && !bank_open[ba]) |=> err_vec[E_RW_IDLE]);

   assert_pre_all_R4: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !ras_n && cas_n && !we_n && a10) |=> bank_open == '0);

   assert_lmr_err_R6: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !ras_n && !cas_n && !we_n && |bank_open) |=> err_vec[E_LMR_BUSY]);

   assert_ref_err_R8: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !ras_n && !cas_n && we_n && cke && |bank_open) |=> err_vec[E_REF_BUSY]);

   assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (err_vec != '0) |=> (err_vec & $past(err_vec)) == $past(err_vec));

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV         = 18;

   localparam logic [3:0] P_NOP = 4'b0111;
   localparam logic [3:0] P_ACT = 4'b0011;
   localparam logic [3:0] P_RD  = 4'b0101;
   localparam logic [3:0] P_WR  = 4'b0100;
   localparam logic [3:0] P_BST = 4'b0110;
   localparam logic [3:0] P_PRE = 4'b0010;
   localparam logic [3:0] P_REF = 4'b0001;
   localparam logic [3:0] P_LMR = 4'b0000;
   localparam logic [3:0] P_DES = 4'b1000;

   // {pins, cke, ba, a10, a_bl, req, exp_cmd, exp_open, exp_err}
   localparam logic [27:0] VEC [NV] = '{
      {P_ACT, 1'b1, 2'd0, 1'b0, 3'd0, 4'd2, 4'd1, 4'b0001, 5'b00000}, // R2
      {P_ACT, 1'b1, 2'd2, 1'b0, 3'd0, 4'd2, 4'd1, 4'b0101, 5'b00000}, // R2
      {P_RD,  1'b1, 2'd0, 1'b0, 3'd0, 4'd1, 4'd2, 4'b0101, 5'b00000}, // R1
      {P_WR,  1'b1, 2'd1, 1'b0, 3'd0, 4'd3, 4'd3, 4'b0101, 5'b00010}, // R3
      {P_PRE, 1'b1, 2'd0, 1'b0, 3'd0, 4'd4, 4'd5, 4'b0100, 5'b00010}, // R4
      {P_BST, 1'b1, 2'd0, 1'b0, 3'd0, 4'd1, 4'd4, 4'b0100, 5'b00010}, // R1
      {P_ACT, 1'b1, 2'd2, 1'b0, 3'd0, 4'd2, 4'd1, 4'b0100, 5'b00011}, // R2
      {P_PRE, 1'b1, 2'd1, 1'b1, 3'd0, 4'd4, 4'd5, 4'b0000, 5'b00011}, // R4
      {P_DES, 1'b1, 2'd0, 1'b0, 3'd0, 4'd1, 4'd0, 4'b0000, 5'b00011}, // R1
      {P_LMR, 1'b1, 2'd0, 1'b0, 3'd1, 4'd6, 4'd8, 4'b0000, 5'b00011}, // R6
      {P_NOP, 1'b1, 2'd0, 1'b0, 3'd0, 4'd7, 4'd0, 4'b0000, 5'b00011}, // R7
      {P_NOP, 1'b1, 2'd0, 1'b0, 3'd0, 4'd7, 4'd0, 4'b0000, 5'b00011}, // R7
      {P_ACT, 1'b1, 2'd3, 1'b0, 3'd0, 4'd7, 4'd1, 4'b1000, 5'b00011}, // R7
      {P_RD,  1'b1, 2'd3, 1'b1, 3'd0, 4'd5, 4'd2, 4'b1000, 5'b00011}, // R5
      {P_NOP, 1'b1, 2'd0, 1'b0, 3'd0, 4'd5, 4'd0, 4'b1000, 5'b00011}, // R5
      {P_NOP, 1'b1, 2'd0, 1'b0, 3'd0, 4'd5, 4'd0, 4'b0000, 5'b00011}, // R5
      {P_REF, 1'b1, 2'd0, 1'b0, 3'd0, 4'd8, 4'd6, 4'b0000, 5'b00011}, // R8
      {P_REF, 1'b0, 2'd0, 1'b0, 3'd0, 4'd8, 4'd7, 4'b0000, 5'b00011}  // R8
   };

   logic       clk = 1'b0;
   logic       rst;
   logic       cs_n, ras_n, cas_n, we_n, cke, a10;
   logic [1:0] ba;
   logic [2:0] a_bl;
   logic [3:0] cmd_code;
   logic [3:0] bank_open;
   logic [4:0] err_vec;
   int         n_chk = 0;
   int         n_err = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sdram_cmd_monitor #(.NBANK(4), .T_MRD(3), .FULL_PAGE(16)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .cke       (cke),
      .ba        (ba),
      .a10       (a10),
      .a_bl      (a_bl),
      .cmd_code  (cmd_code),
      .bank_open (bank_open),
      .err_vec   (err_vec)
   );

   task automatic drive(input logic [3:0] p, input logic k, input logic [1:0] b,
                        input logic ap, input logic [2:0] bl);
      {cs_n, ras_n, cas_n, we_n} = p;
      cke  = k;
      ba   = b;
      a10  = ap;
      a_bl = bl;
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      drive(P_NOP, 1'b1, 2'd0, 1'b0, 3'd0);
      drive(P_NOP, 1'b1, 2'd0, 1'b0, 3'd0);
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      {cs_n, ras_n, cas_n, we_n} = P_NOP;
      cke = 1'b1; ba = '0; a10 = 1'b0; a_bl = '0; rst = 1'b1;
      @(negedge clk);
      do_reset();

      // R9: reset state
      chk("R9 reset cmd",  int'(cmd_code),  0);
      chk("R9 reset open", int'(bank_open), 0);
      chk("R9 reset err",  int'(err_vec),   0);

      for (int i = 0; i < NV; i++) begin
         logic [27:0] v;
         v = VEC[i];
         drive(v[27:24], v[23], v[22:21], v[20], v[19:17]);
         chk($sformatf("R%0d row %0d cmd",  v[16:13], i), int'(cmd_code),  int'(v[12:9]));
         chk($sformatf("R%0d row %0d open", v[16:13], i), int'(bank_open), int'(v[8:5]));
         chk($sformatf("R%0d row %0d err",  v[16:13], i), int'(err_vec),   int'(v[4:0]));
      end

      // R7: command one cycle after mode load
      do_reset();
      drive(P_LMR, 1'b1, 2'd0, 1'b0, 3'd7);
      drive(P_ACT, 1'b1, 2'd0, 1'b0, 3'd0);
      chk("R7 first window cycle", int'(err_vec), 5'b01000);

      // R7: last forbidden cycle
      do_reset();
      drive(P_LMR, 1'b1, 2'd0, 1'b0, 3'd7);
      drive(P_NOP, 1'b1, 2'd0, 1'b0, 3'd0);
      drive(P_ACT, 1'b1, 2'd0, 1'b0, 3'd0);
      chk("R7 last window cycle", int'(err_vec), 5'b01000);

      // R7: first legal cycle
      do_reset();
      drive(P_LMR, 1'b1, 2'd0, 1'b0, 3'd7);
      drive(P_NOP, 1'b1, 2'd0, 1'b0, 3'd0);
      drive(P_NOP, 1'b1, 2'd0, 1'b0, 3'd0);
      drive(P_ACT, 1'b1, 2'd0, 1'b0, 3'd0);
      chk("R7 legal after window err", int'(err_vec),   0);
      chk("R7 legal after window open", int'(bank_open), 4'b0001);

      // R5: full page (16 beats) write with auto precharge
      drive(P_WR, 1'b1, 2'd0, 1'b1, 3'd0);
      for (int j = 0; j < 15; j++) drive(P_NOP, 1'b1, 2'd0, 1'b0, 3'd0);
      chk("R5 full page still open", int'(bank_open), 4'b0001);
      drive(P_NOP, 1'b1, 2'd0, 1'b0, 3'd0);
      chk("R5 full page closed", int'(bank_open), 4'b0000);
      chk("R5 full page no err", int'(err_vec), 0);

      // R8 / R6 / R9: refresh and mode load while a bank is open
      drive(P_ACT, 1'b1, 2'd1, 1'b0, 3'd0);
      drive(P_REF, 1'b1, 2'd0, 1'b0, 3'd0);
      chk("R8 refresh while open", int'(err_vec), 5'b10000);
      drive(P_LMR, 1'b1, 2'd0, 1'b0, 3'd0);
      chk("R6 mode load while open", int'(err_vec), 5'b10100);
      for (int j = 0; j < 3; j++) drive(P_NOP, 1'b1, 2'd0, 1'b0, 3'd0);
      chk("R9 errors sticky", int'(err_vec), 5'b10100);
      do_reset();
      chk("R9 reset clears err",  int'(err_vec),   0);
      chk("R9 reset clears open", int'(bank_open), 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule